// File: doc/BRIEF.md
# Attribute Table Substructure Stream Validator

This block sits on a byte-wide path that carries a device attribute table body, one byte per cycle in which `in_valid` is high. The table is a chain of variable-size substructures. Each substructure opens with a four-byte subheader: a type code, a byte that must be zero, and a 16-bit total length in little-endian order. The block walks the chain as the bytes go by, checks each subheader, and records where each substructure starts and how long it is. The index can later be read back at random through a one-port read interface.

While it walks the chain, the block also keeps an 8-bit running sum of every accepted byte and presents the two's-complement correction byte for it. When the byte flagged with `in_last` arrives, the block checks that the chain closed exactly on that byte. It then freezes until `clr`, which clears every sticky flag, the counters, the sum and the end-of-stream state, and makes the block ready for a new stream.

Top module: `cdat_stream_check`

## Requirements
- R1: A substructure starts at offset 0 or at the previous start plus the previous length (when that length is below 4, the next substructure starts right after the 4-byte subheader). Its start offset and raw length field are written to the next index slot, and `entry_count` counts every substructure seen.
- R2: A length field of zero sets `err_zero_len`.
- R3: A nonzero value in subheader byte 1 sets `err_rsvd_byte`.
- R4: Type codes 0, 1, 2, 3 and 4 must carry total lengths of exactly 24, 18, 20, 8 and 24 bytes. Any other length sets `err_bad_len`.
- R5: Type code 5 must carry a length of at least 16 that is a multiple of 8 (a 16-byte fixed part plus whole 8-byte records). Otherwise `err_bad_len` is set.
- R6: A type code of 6 or more sets `err_rsvd_type`. It never sets `err_bad_len`, whatever its length.
- R7: If the `in_last` byte is not the final byte of a substructure whose length is at least 4, `err_trailing` is set. This also covers a stream that ends inside a subheader.
- R8: `checksum` equals (256 − (sum of all accepted bytes mod 256)) mod 256, so the stream bytes plus `checksum` add to zero modulo 256. It reads 0 after reset or `clr`.
- R9: The index holds DEPTH entries (default 64). A substructure beyond that is counted but not stored, and it sets `idx_overflow`. Exactly DEPTH substructures leave the flag clear.
- R10: All error flags and `idx_overflow` are 0 after reset, stay set once set, and return to 0 only on `clr`. `clr` also zeroes `entry_count`, `checksum` and `stream_done`.
- R11: After the `in_last` byte, `stream_done` is 1 and further valid bytes are ignored (count, checksum and flags stay unchanged) until `clr`.
- R12: The index read port returns {`rd_ofs`, `rd_len`} for `rd_addr` one clock after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clr | input | 1 | Synchronous clear of flags, counters, sum and stream state |
| in_valid | input | 1 | `in_byte` holds a stream byte this cycle |
| in_byte | input | 8 | Stream byte |
| in_last | input | 1 | Marks the final byte of the stream |
| rd_addr | input | clog2(DEPTH) | Index slot to read |
| rd_ofs | output | OFS_W | Start offset of the addressed substructure |
| rd_len | output | OFS_W | Length field of the addressed substructure |
| entry_count | output | OFS_W | Substructures seen since clear |
| checksum | output | 8 | Two's-complement correction byte of the byte sum |
| stream_done | output | 1 | The final byte has been accepted |
| err_zero_len | output | 1 | Sticky: zero length field |
| err_rsvd_byte | output | 1 | Sticky: nonzero reserved subheader byte |
| err_bad_len | output | 1 | Sticky: length not allowed for its type |
| err_rsvd_type | output | 1 | Sticky: reserved type code |
| err_trailing | output | 1 | Sticky: stream did not end on a substructure boundary |
| idx_overflow | output | 1 | Sticky: more substructures than index slots |

## Verification
The bench sweeps every type code from 0 to 7 against a set of lengths that includes each fixed size, 0, an odd value and several multiples of 8. A design with a wrong size table, an off-by-one variable-length rule, or one that gives reserved types a length check would set the wrong flag in at least one cell of that grid. Truncated streams, ending in a body and ending in a subheader, catch a trailing check that only compares against the last body byte. The exact-DEPTH and DEPTH+2 cases catch an overflow that fires one entry early, or one that overwrites slots. Bytes fed after the final byte and a read latency probe catch a block that keeps accepting input or returns index data in the same cycle.

// File: rtl/cdat_chk_pkg.sv
package cdat_chk_pkg;

   localparam int HDR_BYTES      = 4;
   localparam int VAR_TYPE       = 5;
   localparam int VAR_BASE       = 16;
   localparam int VAR_UNIT       = 8;
   localparam logic [7:0] FIRST_RSVD_TYPE = 8'd6;

   typedef enum logic [2:0] {
      PH_TYPE = 3'd0,
      PH_RSVD = 3'd1,
      PH_LLO  = 3'd2,
      PH_LHI  = 3'd3,
      PH_BODY = 3'd4
   } hdr_phase_t;

   function automatic logic is_rsvd_type(input logic [7:0] t);
      return t >= FIRST_RSVD_TYPE;
   endfunction

   function automatic logic len_fits(input logic [7:0] t, input logic [15:0] len);
      logic ok;
      case (t)
         8'd0:    ok = (len == 16'd24);
         8'd1:    ok = (len == 16'd18);
         8'd2:    ok = (len == 16'd20);
         8'd3:    ok = (len == 16'd8);
         8'd4:    ok = (len == 16'd24);
         8'd5:    ok = (len >= 16'(VAR_BASE)) && ((len % 16'(VAR_UNIT)) == 16'd0);
         default: ok = 1'b0;
      endcase
      return ok;
   endfunction

endpackage

// File: rtl/cdat_hdr_parse.sv
module cdat_hdr_parse
   import cdat_chk_pkg::*;
#(
   parameter int OFS_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             beat,
   input  logic [7:0]       byte_i,
   input  logic             last_i,
   output logic             wr_en,
   output logic [OFS_W-1:0] wr_ofs,
   output logic [OFS_W-1:0] wr_len,
   output logic             ev_zero,
   output logic             ev_rsvd,
   output logic             ev_len,
   output logic             ev_type,
   output logic             ev_trail,
   output logic             ev_end
);

   if (OFS_W < 16) begin : g_bad_width
      $error("cdat_hdr_parse: OFS_W must hold a 16-bit length");
   end

   hdr_phase_t       phase;
   logic [OFS_W-1:0] pos;
   logic [OFS_W-1:0] start;
   logic [OFS_W-1:0] rem;
   logic [7:0]       typ;
   logic [7:0]       len_lo;
   logic [15:0]      len_full;
   logic             ends_here;

   assign len_full = {byte_i, len_lo};

   always_comb begin
      wr_en     = beat && (phase == PH_LHI);
      wr_ofs    = start;
      wr_len    = OFS_W'(len_full);
      ev_type   = beat && (phase == PH_TYPE) && is_rsvd_type(byte_i);
      ev_rsvd   = beat && (phase == PH_RSVD) && (byte_i != 8'd0);
      ev_zero   = wr_en && (len_full == 16'd0);
      ev_len    = wr_en && !is_rsvd_type(typ) && !len_fits(typ, len_full);
      ends_here = ((phase == PH_LHI) && (len_full == 16'(HDR_BYTES))) ||
                  ((phase == PH_BODY) && (rem == OFS_W'(1)));
      ev_end    = beat && last_i;
      ev_trail  = ev_end && !ends_here;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         phase  <= PH_TYPE;
         pos    <= '0;
         start  <= '0;
         rem    <= '0;
         typ    <= '0;
         len_lo <= '0;
      end else if (beat) begin
         pos <= pos + OFS_W'(1);
         case (phase)
            PH_TYPE: begin
               typ   <= byte_i;
               start <= pos;
               phase <= PH_RSVD;
            end
            PH_RSVD: phase <= PH_LLO;
            PH_LLO: begin
               len_lo <= byte_i;
               phase  <= PH_LHI;
            end
            PH_LHI: begin
               if (len_full <= 16'(HDR_BYTES)) begin
                  phase <= PH_TYPE;
               end else begin
                  rem   <= OFS_W'(len_full) - OFS_W'(HDR_BYTES);
                  phase <= PH_BODY;
               end
            end
            default: begin
               if (rem == OFS_W'(1)) phase <= PH_TYPE;
               rem <= rem - OFS_W'(1);
            end
         endcase
      end
   end

   AST_BODY_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_BODY) |-> (rem != '0)); // R1

   AST_START_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
      (beat && !clr && phase == PH_TYPE) |=> (start == $past(pos))); // R1

endmodule

// File: rtl/cdat_index_ram.sv
module cdat_index_ram #(
   parameter int DEPTH    = 64,
   parameter int OFS_W    = 16,
   parameter bit REG_READ = 1'b1,
   localparam int AW      = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             we,
   input  logic [AW-1:0]    waddr,
   input  logic [OFS_W-1:0] wofs,
   input  logic [OFS_W-1:0] wlen,
   input  logic [AW-1:0]    raddr,
   output logic [OFS_W-1:0] rofs,
   output logic [OFS_W-1:0] rlen
);

   if (DEPTH < 2) begin : g_bad_depth
      $error("cdat_index_ram: DEPTH must be at least 2");
   end

   logic [2*OFS_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= {wofs, wlen};
   end

   if (REG_READ) begin : g_reg_rd
      logic [2*OFS_W-1:0] rd_q;
      always_ff @(posedge clk) rd_q <= mem[raddr];
      assign {rofs, rlen} = rd_q;
   end else begin : g_comb_rd
      assign {rofs, rlen} = mem[raddr];
   end

endmodule

// File: rtl/cdat_csum.sv
module cdat_csum (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clr,
   input  logic       beat,
   input  logic [7:0] byte_i,
   output logic [7:0] csum_o
);

   logic [7:0] sum_q;

   always_ff @(posedge clk) begin
      if (!rst_n || clr)  sum_q <= '0;
      else if (beat)      sum_q <= sum_q + byte_i;
   end

   assign csum_o = 8'(8'd0 - sum_q);

   AST_CSUM_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!beat && !clr) |=> $stable(csum_o)); // R8

endmodule

// File: rtl/cdat_stream_check.sv
module cdat_stream_check #(
   parameter int DEPTH    = 64,
   parameter int OFS_W    = 16,
   parameter bit REG_READ = 1'b1,
   localparam int AW      = $clog2(DEPTH),
   localparam int NFLAG   = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             in_valid,
   input  logic [7:0]       in_byte,
   input  logic             in_last,
   input  logic [AW-1:0]    rd_addr,
   output logic [OFS_W-1:0] rd_ofs,
   output logic [OFS_W-1:0] rd_len,
   output logic [OFS_W-1:0] entry_count,
   output logic [7:0]       checksum,
   output logic             stream_done,
   output logic             err_zero_len,
   output logic             err_rsvd_byte,
   output logic             err_bad_len,
   output logic             err_rsvd_type,
   output logic             err_trailing,
   output logic             idx_overflow
);

   if (AW >= OFS_W) begin : g_bad_cfg
      $error("cdat_stream_check: DEPTH too large for OFS_W");
   end

   logic             beat;
   logic             wr_en, ram_we;
   logic [OFS_W-1:0] wr_ofs, wr_len;
   logic             ev_zero, ev_rsvd, ev_len, ev_type, ev_trail, ev_end;
   logic [NFLAG-1:0] ev_vec, flag_q;

   assign beat   = in_valid && !stream_done;
   assign ev_vec = {ev_zero, ev_rsvd, ev_len, ev_type, ev_trail};
   assign ram_we = wr_en && (entry_count < OFS_W'(DEPTH));

   cdat_hdr_parse #(.OFS_W(OFS_W)) u_parse (
      .clk, .rst_n, .clr, .beat,
      .byte_i(in_byte), .last_i(in_last),
      .wr_en, .wr_ofs, .wr_len,
      .ev_zero, .ev_rsvd, .ev_len, .ev_type, .ev_trail, .ev_end
   );

   cdat_index_ram #(.DEPTH(DEPTH), .OFS_W(OFS_W), .REG_READ(REG_READ)) u_idx (
      .clk, .we(ram_we), .waddr(entry_count[AW-1:0]),
      .wofs(wr_ofs), .wlen(wr_len),
      .raddr(rd_addr), .rofs(rd_ofs), .rlen(rd_len)
   );

   cdat_csum u_sum (
      .clk, .rst_n, .clr, .beat, .byte_i(in_byte), .csum_o(checksum)
   );

   for (genvar i = 0; i < NFLAG; i++) begin : g_flag
      always_ff @(posedge clk) begin
         if (!rst_n || clr)  flag_q[i] <= 1'b0;
         else if (ev_vec[i]) flag_q[i] <= 1'b1;
      end
      AST_STICKY_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
         (flag_q[i] && !clr) |=> flag_q[i]); // R10
   end

   assign {err_zero_len, err_rsvd_byte, err_bad_len, err_rsvd_type, err_trailing} = flag_q;

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         entry_count  <= '0;
         idx_overflow <= 1'b0;
         stream_done  <= 1'b0;
      end else begin
         if (wr_en)            entry_count  <= entry_count + OFS_W'(1);
         if (wr_en && !ram_we) idx_overflow <= 1'b1;
         if (ev_end)           stream_done  <= 1'b1;
      end
   end

   AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (stream_done && !clr) |=> stream_done); // R11

   AST_COUNT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (stream_done && !clr) |=> $stable(entry_count)); // R11

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(idx_overflow) |-> (entry_count > OFS_W'(DEPTH))); // R9

   AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (idx_overflow && !clr) |=> idx_overflow); // R10

endmodule

// File: tb/sim_cdat_stream_check.sv
module sim_cdat_stream_check;
   localparam int DEPTH = 4;
   localparam int OFS_W = 16;
   localparam int AW    = 2;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic             rst_n, clr, in_valid, in_last;
   logic [7:0]       in_byte;
   logic [AW-1:0]    rd_addr;
   logic [OFS_W-1:0] rd_ofs, rd_len, entry_count;
   logic [7:0]       checksum;
   logic stream_done, err_zero_len, err_rsvd_byte, err_bad_len, err_rsvd_type,
         err_trailing, idx_overflow;

   cdat_stream_check #(.DEPTH(DEPTH), .OFS_W(OFS_W), .REG_READ(1'b1)) u0 (
      .clk, .rst_n, .clr, .in_valid, .in_byte, .in_last, .rd_addr,
      .rd_ofs, .rd_len, .entry_count, .checksum, .stream_done,
      .err_zero_len, .err_rsvd_byte, .err_bad_len, .err_rsvd_type,
      .err_trailing, .idx_overflow
   );

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 0;

   logic [7:0] sbuf [0:511];
   int slen;
   int nent;
   int ofs_q [0:31];
   int len_q [0:31];

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic logic [4:0] flags();
      return {err_zero_len, err_rsvd_byte, err_bad_len, err_rsvd_type, err_trailing};
   endfunction

   function automatic logic [7:0] exp_csum();
      logic [7:0] s = 8'd0;
      for (int i = 0; i < slen; i++) s = s + sbuf[i];
      return 8'(8'd0 - s);
   endfunction

   task automatic start_stream();
      slen = 0;
      nent = 0;
   endtask

   task automatic add_struct(input int t, input int rsvd, input int len, input int nsend);
      logic [7:0] hb [4];
      hb[0] = 8'(t); hb[1] = 8'(rsvd); hb[2] = 8'(len); hb[3] = 8'(len >> 8);
      if (nsend >= 4) begin
         ofs_q[nent] = slen;
         len_q[nent] = len;
         nent++;
      end
      for (int k = 0; k < nsend; k++) begin
         sbuf[slen] = (k < 4) ? hb[k] : 8'(slen * 13 + 5);
         slen++;
      end
   endtask

   task automatic do_clr();
      clr = 1'b1;
      @(negedge clk);
      clr = 1'b0;
      @(negedge clk);
   endtask

   task automatic send_stream(input bit gap);
      for (int i = 0; i < slen; i++) begin
         in_valid = 1'b1;
         in_byte  = sbuf[i];
         in_last  = (i == slen - 1);
         @(negedge clk);
         if (gap && (i % 3 == 1)) begin
            in_valid = 1'b0;
            @(negedge clk);
         end
      end
      in_valid = 1'b0;
      in_last  = 1'b0;
      @(negedge clk);
   endtask

   task automatic check_index(input string req);
      int n = (nent < DEPTH) ? nent : DEPTH;
      for (int e = 0; e < n; e++) begin
         rd_addr = AW'(e);
         @(negedge clk);
         check(req, $sformatf("index %0d offset", e), 32'(rd_ofs), 32'(ofs_q[e]));
         check(req, $sformatf("index %0d length", e), 32'(rd_len), 32'(len_q[e]));
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      int fixed_len [0:7];
      int lens [0:7];
      logic [7:0] saved_csum;
      fixed_len = '{24, 18, 20, 8, 24, 0, 0, 0};
      lens      = '{0, 8, 16, 18, 20, 24, 25, 40};
      rst_n = 1'b0; clr = 1'b0; in_valid = 1'b0; in_last = 1'b0;
      in_byte = 8'd0; rd_addr = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R10: reset state
      check("R10", "flags after reset", 32'(flags()), 32'd0);
      check("R10", "overflow after reset", 32'(idx_overflow), 32'd0);
      check("R10", "count after reset", 32'(entry_count), 32'd0);
      check("R8", "checksum after reset", 32'(checksum), 32'd0);
      check("R11", "done after reset", 32'(stream_done), 32'd0);

      // R1 R4 R5 R8 R9: clean stream with exactly DEPTH entries, with gaps
      start_stream();
      add_struct(0, 0, 24, 24);
      add_struct(3, 0, 8, 8);
      add_struct(5, 0, 32, 32);
      add_struct(1, 0, 18, 18);
      send_stream(1'b1);
      check("R4", "flags clean stream", 32'(flags()), 32'd0);
      check("R1", "count clean stream", 32'(entry_count), 32'd4);
      check("R9", "no overflow at exactly DEPTH", 32'(idx_overflow), 32'd0);
      check("R8", "checksum clean stream", 32'(checksum), 32'(exp_csum()));
      check("R11", "done after last", 32'(stream_done), 32'd1);
      check_index("R1");

      // R12: read data lags the address by one clock
      rd_addr = 2'd0;
      @(negedge clk);
      rd_addr = 2'd2;
      #1;
      check("R12", "old data before edge", 32'(rd_ofs), 32'(ofs_q[0]));
      @(negedge clk);
      check("R12", "new data after edge", 32'(rd_ofs), 32'(ofs_q[2]));

      // R2 R4 R5 R6 R7: type x length sweep
      for (int t = 0; t < 8; t++) begin
         for (int li = 0; li < 8; li++) begin
            int L = lens[li];
            logic exp_len;
            do_clr();
            start_stream();
            add_struct(t, 0, L, (L < 4) ? 4 : L);
            send_stream(1'b0);
            if (t <= 4)      exp_len = (L != fixed_len[t]);
            else if (t == 5) exp_len = (L < 16) || (L % 8 != 0);
            else             exp_len = 1'b0;
            check((t == 5) ? "R5" : "R4", $sformatf("bad_len t=%0d len=%0d", t, L),
                  32'(err_bad_len), 32'(exp_len));
            check("R6", $sformatf("rsvd_type t=%0d len=%0d", t, L),
                  32'(err_rsvd_type), 32'(t >= 6));
            check("R2", $sformatf("zero_len t=%0d len=%0d", t, L),
                  32'(err_zero_len), 32'(L == 0));
            check("R7", $sformatf("trailing t=%0d len=%0d", t, L),
                  32'(err_trailing), 32'(L < 4));
            check("R8", $sformatf("checksum t=%0d len=%0d", t, L),
                  32'(checksum), 32'(exp_csum()));
         end
      end

      // R3: nonzero reserved byte
      do_clr();
      start_stream();
      add_struct(3, 5, 8, 8);
      add_struct(3, 0, 8, 8);
      send_stream(1'b0);
      check("R3", "reserved byte flag", 32'(flags()), 32'b01000);
      check("R1", "count with reserved error", 32'(entry_count), 32'd2);

      // R7: stream ends inside a body
      do_clr();
      start_stream();
      add_struct(0, 0, 24, 10);
      send_stream(1'b0);
      check("R7", "end inside body", 32'(flags()), 32'b00001);

      // R7: stream ends inside a subheader
      do_clr();
      start_stream();
      add_struct(3, 0, 8, 8);
      add_struct(3, 0, 8, 2);
      send_stream(1'b0);
      check("R7", "end inside subheader", 32'(flags()), 32'b00001);

      // R9: overflow beyond DEPTH
      do_clr();
      start_stream();
      for (int k = 0; k < DEPTH + 2; k++) add_struct(3, 0, 8, 8);
      send_stream(1'b1);
      check("R9", "overflow flag", 32'(idx_overflow), 32'd1);
      check("R9", "count past depth", 32'(entry_count), 32'(DEPTH + 2));
      check_index("R9");

      // R10: sticky error, then clear
      do_clr();
      start_stream();
      add_struct(7, 0, 8, 8);
      add_struct(0, 0, 24, 24);
      send_stream(1'b0);
      check("R10", "reserved type held to end", 32'(flags()), 32'b00010);
      do_clr();
      check("R10", "flags after clr", 32'(flags()), 32'd0);
      check("R10", "count after clr", 32'(entry_count), 32'd0);
      check("R10", "checksum after clr", 32'(checksum), 32'd0);
      check("R10", "done after clr", 32'(stream_done), 32'd0);

      // R11: bytes after the final byte are ignored
      start_stream();
      add_struct(3, 0, 8, 8);
      send_stream(1'b0);
      saved_csum = checksum;
      for (int k = 0; k < 8; k++) begin
         in_valid = 1'b1;
         in_byte  = (k == 0) ? 8'd9 : 8'(k + 40);
         in_last  = (k == 7);
         @(negedge clk);
      end
      in_valid = 1'b0;
      in_last  = 1'b0;
      @(negedge clk);
      check("R11", "count frozen", 32'(entry_count), 32'd1);
      check("R11", "checksum frozen", 32'(checksum), 32'(saved_csum));
      check("R11", "flags untouched", 32'(flags()), 32'd0);
      check("R11", "still done", 32'(stream_done), 32'd1);

      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule